// File: doc/BRIEF.md
# Low-Power Idle Clock Divider Controller

This block manages a processor core's idle state. When the core asks to idle, the request can pick one of two modes. In plain idle, the core clock-enable keeps running at the full rate. In divided idle, the clock-enable fires only once every n cycles, where n is 16, 32, 64 or 128, chosen by a 2-bit code. An enabled interrupt ends the idle state. In plain idle it does so on the next cycle. In divided idle it is only sampled on the cycles where the slowed clock-enable fires, so wake-up can take up to n full-rate cycles.

The block reports that the core is idle, and gives a single-cycle wake pulse when the idle state ends. Gating cells and interrupt vectoring sit outside the block. The core uses the clock-enable, and the wake pulse can resume an instruction sequencer.

Top module: `idle_clk_div`

## Requirements
- R1: The divisor code selects n = 16 << div_code: code 0 gives 16, 1 gives 32, 2 gives 64 and 3 gives 128. `div_en` = 1 selects divided idle and `div_en` = 0 selects plain idle.
- R2: An `idle_req` sampled while running, with no enabled interrupt pending, raises `idle_active` in the following cycle.
- R3: In plain idle, `core_ce` is high on every cycle. An enabled interrupt sampled at a clock edge ends idle on the cycle after that edge.
- R4: In divided idle, `core_ce` is high on one cycle in n. The divide counter restarts on entry, so the first pulse falls on the n-th idle cycle.
- R5: In divided idle, an enabled interrupt is acted on only at an edge that ends a `core_ce` pulse cycle. Wake-up therefore follows within at most n cycles of a pending enabled interrupt.
- R6: An interrupt is enabled only where the same bit of `irq_enable` is 1. Pending bits whose enable bit is 0 never end idle.
- R7: `wake` is high for exactly one cycle. That cycle is the first cycle with `idle_active` low. `core_ce` is low during the wake cycle and high on every cycle after it until the next idle.
- R8: An `idle_req` sampled while an enabled interrupt is pending is ignored, and the block keeps running.
- R9: Reset, active low and asynchronous, forces running state, including in the middle of an idle: `idle_active` = 0, `wake` = 0, `core_ce` = 1, and the counter cleared.
- R10: The mode and divisor are captured on entry. Changes to `div_code`, `div_en` or `idle_req` while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req | input | 1 | Request to enter idle |
| div_en | input | 1 | 1 selects divided idle, 0 selects plain idle |
| div_code | input | 2 | Divisor selector, n = 16 << code |
| irq_pend | input | IRQ_W | Pending interrupt lines |
| irq_enable | input | IRQ_W | Per-line interrupt enable, 1 = enabled |
| core_ce | output | 1 | Core clock-enable |
| idle_active | output | 1 | High while the core is idle |
| wake | output | 1 | One-cycle pulse when idle ends |

## Verification
The assertions check several rules on every cycle:
- `wake` is a single cycle and coincides with the fall of `idle_active`.
- In divided idle, wake-up happens only at a pulse edge.
- `core_ce` pulses in divided idle are isolated.
- Masked interrupts cannot end idle.
- Ignored requests leave the block running.

The exact pulse spacing for each divisor code, the first pulse falling on the n-th idle cycle, and the real wake latency from a given interrupt arrival are shown only by the bench scenarios. The same holds for capture of the mode at entry and for a reset in the middle of an idle.

// File: rtl/idle_clk_div.sv
module idle_clk_div #(
  parameter int IRQ_W = 8,
  parameter int BASE_LOG2 = 4,
  parameter int CODE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req,
  input  logic             div_en,
  input  logic [CODE_W-1:0] div_code,
  input  logic [IRQ_W-1:0] irq_pend,
  input  logic [IRQ_W-1:0] irq_enable,
  output logic             core_ce,
  output logic             idle_active,
  output logic             wake
);

  localparam int MAX_CODE = (1 << CODE_W) - 1;
  localparam int CNT_W = BASE_LOG2 + MAX_CODE;

  typedef enum logic [1:0] {ST_RUN, ST_PLAIN, ST_DIV} st_e;

  st_e             st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic            wake_q;
  logic            hit;
  logic            tick;
  logic [CNT_W-1:0] lim_nx;

  assign hit    = |(irq_pend & irq_enable);
  assign tick   = (st == ST_DIV) && (cnt == lim);
  assign lim_nx = {CNT_W{1'b1}} >> (CODE_W'(MAX_CODE) - div_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_RUN;
      cnt    <= '0;
      lim    <= '0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= 1'b0;
      case (st)
        ST_RUN: begin
          if (idle_req && !hit) begin
            st  <= div_en ? ST_DIV : ST_PLAIN;
            cnt <= '0;
            lim <= lim_nx;
          end
        end
        ST_PLAIN: begin
          if (hit) begin
            st     <= ST_RUN;
            wake_q <= 1'b1;
          end
        end
        ST_DIV: begin
          if (tick && hit) begin
            st     <= ST_RUN;
            wake_q <= 1'b1;
            cnt    <= '0;
          end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign core_ce     = ((st == ST_RUN) && !wake_q) || (st == ST_PLAIN) || tick;
  assign idle_active = (st != ST_RUN);
  assign wake        = wake_q;

  p_wake_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  p_wake_idle_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (!idle_active && $past(idle_active)));
  p_wake_ce_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> core_ce);
  p_plain_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PLAIN && hit) |=> wake);
  p_div_sparse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DIV && core_ce) |=> !core_ce);
  p_div_wake_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && $past(st == ST_DIV)) |-> $past(tick));
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DIV) |-> (cnt <= lim));
  p_masked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_active && !hit) |=> idle_active);
  p_req_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_active && idle_req && hit) |=> !idle_active);

endmodule

// File: tb/idle_clk_div_bench.sv
module idle_clk_div_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle_req = 1'b0;
  logic div_en = 1'b0;
  logic [1:0] div_code = 2'd0;
  logic [7:0] irq_pend = '0;
  logic [7:0] irq_enable = '0;
  logic core_ce, idle_active, wake;

  always #2 clk = ~clk;

  idle_clk_div u_idle_clk_div (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .div_en(div_en),
    .div_code(div_code), .irq_pend(irq_pend), .irq_enable(irq_enable),
    .core_ce(core_ce), .idle_active(idle_active), .wake(wake));

  typedef struct {
    logic  ce;
    logic  idle;
    logic  wk;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  // Reference expectation built from the requirements
  int m_st = 0;
  int m_cnt = 0;
  int m_n = 16;
  bit m_wake = 0;

  task automatic step(bit r, bit req, bit den, logic [1:0] dc,
                      logic [7:0] p, logic [7:0] e, string tag);
    exp_t x;
    bit h;
    @(posedge clk);
    #1;
    rst_n = r; idle_req = req; div_en = den; div_code = dc;
    irq_pend = p; irq_enable = e;
    if (!r) begin m_st = 0; m_cnt = 0; m_wake = 0; end
    x.idle = (m_st != 0);
    x.wk   = m_wake;
    x.ce   = (m_st == 0) ? !m_wake : (m_st == 1) ? 1'b1 : (m_cnt == m_n - 1);
    x.tag  = tag;
    q.push_back(x);
    if (r) begin
      h = |(p & e);
      case (m_st)
        0: begin
          m_wake = 0;
          if (req && !h) begin m_st = den ? 2 : 1; m_n = 16 << dc; m_cnt = 0; end
        end
        1: begin
          m_wake = 0;
          if (h) begin m_st = 0; m_wake = 1; end
        end
        default: begin
          m_wake = 0;
          if (m_cnt == m_n - 1 && h) begin m_st = 0; m_wake = 1; m_cnt = 0; end
          else m_cnt = (m_cnt == m_n - 1) ? 0 : m_cnt + 1;
        end
      endcase
    end
  endtask

  task automatic steps(int k, bit r, bit req, bit den, logic [1:0] dc,
                       logic [7:0] p, logic [7:0] e, string tag);
    for (int i = 0; i < k; i++) step(r, req, den, dc, p, e, tag);
  endtask

  initial begin
    exp_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (core_ce !== it.ce || idle_active !== it.idle || wake !== it.wk) begin
          errors++;
          $display("FAIL %s: got ce=%b idle=%b wake=%b exp ce=%b idle=%b wake=%b",
                   it.tag, core_ce, idle_active, wake, it.ce, it.idle, it.wk);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: got running exp finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    steps(3, 0, 0, 0, 0, 8'h00, 8'h00, "R9 reset state");
    steps(2, 1, 0, 0, 0, 8'h00, 8'h00, "R9 after reset");
    // plain idle
    step(1, 1, 0, 0, 8'h00, 8'h00, "R2 enter plain idle");
    steps(6, 1, 0, 0, 0, 8'h04, 8'h00, "R6 masked irq holds idle");
    steps(2, 1, 1, 1, 3, 8'h00, 8'hff, "R10 requests during plain idle");
    step(1, 0, 0, 0, 8'h04, 8'h04, "R3 plain wake next cycle");
    step(1, 0, 0, 0, 8'h00, 8'h00, "R7 wake pulse");
    steps(3, 1, 0, 0, 0, 8'h00, 8'h00, "R7 full rate after wake");
    // ignored request
    step(1, 1, 0, 0, 8'h01, 8'h01, "R8 request with pending irq");
    steps(3, 1, 0, 0, 0, 8'h01, 8'h01, "R8 stays running");
    steps(2, 1, 0, 0, 0, 8'h00, 8'h00, "R8 settle");
    // divided idle, long quiet stretch on code 0
    step(1, 1, 1, 0, 8'h00, 8'h00, "R1 enter divided n=16");
    steps(40, 1, 0, 0, 0, 8'h80, 8'h7f, "R4 pulse spacing n=16");
    steps(20, 1, 0, 0, 0, 8'h80, 8'h80, "R5 wake on pulse n=16");
    steps(3, 1, 0, 0, 0, 8'h00, 8'h00, "R7 run after divided wake");
    for (int c = 0; c < 4; c++) begin
      step(1, 1, 1, 2'(c), 8'h00, 8'h00, "R1 enter divided per code");
      steps(5 + c * 7, 1, 0, 1, 2'(c), 8'h00, 8'h00, "R4 idle per code");
      steps(3, 1, 1, 0, 2'(3 - c), 8'h00, 8'h00, "R10 changes ignored in idle");
      steps(140, 1, 0, 0, 0, 8'h02, 8'h02, "R5 wake latency per code");
      steps(3, 1, 0, 0, 0, 8'h00, 8'h00, "R7 run per code");
    end
    // reset in the middle of divided idle
    step(1, 1, 1, 2, 8'h00, 8'h00, "R2 enter before reset");
    steps(10, 1, 0, 0, 0, 8'h00, 8'h00, "R4 idle before reset");
    step(0, 0, 0, 0, 8'h00, 8'h00, "R9 mid-idle reset");
    steps(3, 1, 0, 0, 0, 8'h00, 8'h00, "R9 running after reset");
    @(negedge clk);
    @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule